// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block checks a 512-byte data block against its 3-byte Hamming code. It compares the code stored with the data against the code recomputed when the data is read back, classifies the outcome, and finds the flipped bit when a single data bit is wrong. The caller presents the two 24-bit codes and pulses `start`. The block then returns a 2-bit status code, a 9-bit byte index, a 3-bit bit index and a one-cycle `done` pulse.

The 24-bit syndrome is the XOR of the two codes. Within it, bits 2k and 2k+1 form one parity pair, for k from 0 to 11. A single data-bit error inverts exactly one member of every pair. An erased page carries an all-ones stored code. When the `ign_blank` option is set, such a page is treated as clean.

Correction of the buffer is optional and is enabled by `fix_en`. When it is enabled and a data bit is corrected, the block does a read-modify-write on a byte-wide buffer port. It flips the bit and writes the byte back before it signals `done`.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: A syndrome of zero gives status 00 (clean), and both byte_idx and bit_idx read 0.
- R2: When ign_blank is 1 and the stored code is 24'hFFFFFF, the status is 00 whatever the syndrome. When ign_blank is 0, the same codes are classified normally.
- R3: The status is 01 (data bit corrected) when bits 2k and 2k+1 of the syndrome differ for every k from 0 to 11.
- R4: For status 01, bit_idx is {syn[23], syn[21], syn[19]}, with syn[19] as the least significant bit.
- R5: For status 01, byte_idx is {syn[17], syn[15], ..., syn[3], syn[1]}, with syn[1] as the least significant bit.
- R6: A syndrome that is not correctable under R3 but has exactly one bit set gives status 10 (stored code corrected), with both indices 0.
- R7: Any other nonzero syndrome gives status 11 (uncorrectable), with both indices 0.
- R8: With fix_en high and status 01, the block asserts mem_rd for one cycle at address byte_idx. In the next cycle it asserts mem_wr with mem_rdata XOR (1 << bit_idx). In the cycle after that it asserts done. The buffer port has a read latency of one cycle.
- R9: mem_rd and mem_wr stay low whenever fix_en is low or the status is not 01.
- R10: done is high for exactly one cycle. It comes in the cycle after the accepted start when there is no memory access, and three cycles after it when there is one.
- R11: The outputs change only on an accepted start. A start that arrives while a read-modify-write is in progress is ignored.
- R12: After reset, status is 00, both indices are 0, and done, mem_rd and mem_wr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a comparison of the codes on `stored` and `calc` |
| ign_blank | input | 1 | Treats an all-ones stored code as an erased, clean page |
| fix_en | input | 1 | Enables the read-modify-write correction |
| stored | input | 24 | Code read from the spare area |
| calc | input | 24 | Code recomputed over the data |
| status | output | 2 | Result: 00 clean, 01 data bit fixed, 10 code bit fixed, 11 uncorrectable |
| byte_idx | output | 9 | Byte holding the bad bit |
| bit_idx | output | 3 | Bit within that byte |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Buffer read data, valid one cycle after mem_rd |

## Verification
Most faults in the classifier are visible at the ports in the cycle right after start, because status and both indices are registered on that edge. A wrong pair test or a wrong index mapping therefore shows immediately as a mismatched status, byte_idx or bit_idx. A fault in the sequencing state shows up instead as a missing or misplaced mem_rd, mem_wr or done strobe within three cycles. It also shows as a wrong byte left in the buffer, which the reference model compares when done rises.

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix #(
  parameter int CODE_W = 24,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 ign_blank,
  input  logic                 fix_en,
  input  logic [CODE_W-1:0]    stored,
  input  logic [CODE_W-1:0]    calc,
  output logic [1:0]           status,
  output logic [8:0]           byte_idx,
  output logic [2:0]           bit_idx,
  output logic                 done,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [8:0]           mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata
);
  localparam int NPAIR = CODE_W / 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t state;

  logic [CODE_W-1:0] syn;
  logic [NPAIR-1:0]  pdiff, odd;
  logic              blank, single;
  logic [1:0]        cls;

  assign syn    = stored ^ calc;
  assign blank  = ign_blank && (&stored);
  assign single = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pdiff[k] = syn[2*k] ^ syn[2*k+1];
    assign odd[k]   = syn[2*k+1];
  end

  always_comb begin
    if (syn == '0 || blank) cls = 2'b00;
    else if (&pdiff)        cls = 2'b01;
    else if (single)        cls = 2'b10;
    else                    cls = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      status   <= 2'b00;
      byte_idx <= '0;
      bit_idx  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          status   <= cls;
          byte_idx <= (cls == 2'b01) ? odd[8:0]  : 9'd0;
          bit_idx  <= (cls == 2'b01) ? odd[11:9] : 3'd0;
          if (fix_en && cls == 2'b01) state <= S_RD;
          else                        done  <= 1'b1;
        end
        S_RD: state <= S_WR;
        S_WR: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_addr  = byte_idx;
  assign mem_wdata = mem_rdata ^ (DATA_W'(1) << bit_idx);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr); // R8
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> done); // R8
  AST_MEM_ONLY_DATAFIX: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> status == 2'b01); // R9
  AST_HOLD_STATUS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(status) && $stable(byte_idx)); // R11
  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status != 2'b01 |-> byte_idx == 9'd0 && bit_idx == 3'd0); // R6
endmodule

// File: tb/sim_ecc_syndrome_fix.sv
module sim_ecc_syndrome_fix;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, ign_blank = 0, fix_en = 0;
  logic [23:0] stored = 0, calc = 0;
  logic [1:0] status;
  logic [8:0] byte_idx, mem_addr;
  logic [2:0] bit_idx;
  logic done, mem_rd, mem_wr;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [512];
  logic [7:0] emem [512];

  always #(PERIOD/2) clk = ~clk;

  ecc_syndrome_fix u0 (.clk, .rst_n, .start, .ign_blank, .fix_en, .stored, .calc,
    .status, .byte_idx, .bit_idx, .done, .mem_rd, .mem_wr, .mem_addr, .mem_wdata, .mem_rdata);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void classify(input logic [23:0] st, input logic [23:0] ca, input bit ign,
                                   output int cls, output int b, output int t);
    logic [23:0] s = st ^ ca;
    bit ok = 1;
    for (int k = 0; k < 12; k++) if (s[2*k] == s[2*k+1]) ok = 0;
    b = 0; t = 0;
    if (s == 0 || (ign && st == 24'hFFFFFF)) cls = 0;
    else if (ok) begin
      cls = 1;
      for (int i = 0; i < 9; i++) b += int'(s[2*i+1]) << i;
      for (int i = 0; i < 3; i++) t += int'(s[19+2*i]) << i;
    end else if ($countones(s) == 1) cls = 2;
    else cls = 3;
  endfunction

  function automatic logic [23:0] mk(input int b, input int t);
    logic [23:0] s;
    logic [11:0] v = {t[2:0], b[8:0]};
    for (int i = 0; i < 12; i++) begin s[2*i+1] = v[i]; s[2*i] = ~v[i]; end
    return s;
  endfunction

  int e_status, e_byte, e_bit, c;
  bit e_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_status <= 0; e_byte <= 0; e_bit <= 0; e_done <= 0; c <= 0;
    end else if (c > 0) begin
      c <= c - 1;
      e_done <= (c == 1);
    end else if (start) begin
      int cl, b, t;
      classify(stored, calc, ign_blank, cl, b, t);
      e_status <= cl; e_byte <= b; e_bit <= t;
      if (fix_en && cl == 1) begin
        c <= 2; e_done <= 0;
        emem[b] <= emem[b] ^ (8'd1 << t);
      end else e_done <= 1;
    end else e_done <= 0;
  end

  always @(negedge clk) if (rst_n) begin
    check(status == 2'(e_status), "R3/R6/R7 status", status, e_status);
    check(byte_idx == 9'(e_byte), "R5 byte_idx", byte_idx, e_byte);
    check(bit_idx == 3'(e_bit), "R4 bit_idx", bit_idx, e_bit);
    check(done == e_done, "R10 done", done, e_done);
    check(mem_rd == (c == 2), "R8 mem_rd", mem_rd, c == 2);
    check(mem_wr == (c == 1), "R9 mem_wr", mem_wr, c == 1);
    if (done) check(mem[byte_idx] == emem[byte_idx], "R8 buffer byte", mem[byte_idx], emem[byte_idx]);
  end

  task automatic run(input logic [23:0] st, input logic [23:0] ca, input bit ign, input bit fix);
    @(negedge clk);
    stored = st; calc = ca; ign_blank = ign; fix_en = fix; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = 8'(i * 37 + 5); emem[i] = 8'(i * 37 + 5); end
    repeat (3) @(negedge clk);
    check(status == 0 && byte_idx == 0 && bit_idx == 0 && !done && !mem_rd && !mem_wr,
          "R12 reset state", {status, done, mem_rd, mem_wr}, 0);
    rst_n = 1;
    run(24'h123456, 24'h123456, 0, 1);          // R1 clean
    run(24'hFFFFFF, 24'h0F0F0F, 1, 1);          // R2 blank ignored
    run(24'hFFFFFF, 24'hFFFFFF ^ mk(3, 2), 0, 1); // R2 not ignored -> fix
    run(24'hABCDEF, 24'hABCDEF ^ mk(100, 5), 0, 1); // R3 R4 R5 R8 fix
    run(24'h000000, mk(200, 6), 1, 0);          // R9 no fix
    run(24'h000000, 24'h555555, 0, 1);          // byte 0 bit 0
    run(24'h000000, 24'hAAAAAA, 0, 1);          // byte 511 bit 7
    run(24'h111111, 24'h111111 ^ 24'h000400, 0, 1); // R6 single bit
    run(24'h000000, 24'h000003, 0, 1);          // R7
    // R11: second start during the read-modify-write is ignored
    @(negedge clk);
    stored = 0; calc = mk(7, 1); fix_en = 1; ign_blank = 0; start = 1;
    @(negedge clk);
    calc = 24'h000003;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 300; n++) begin
      logic [23:0] s0 = 24'($urandom);
      logic [23:0] d;
      case (n % 4)
        0: d = mk(int'($urandom_range(0, 511)), int'($urandom_range(0, 7)));
        1: d = 24'(1) << $urandom_range(0, 23);
        2: d = 24'($urandom);
        default: d = 0;
      endcase
      run((n % 7 == 0) ? 24'hFFFFFF : s0, ((n % 7 == 0) ? 24'hFFFFFF : s0) ^ d, n[0], n[1]);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule